// File: doc/BRIEF.md
# Dual-Width Block-Code Serializer

This block turns parallel block-coded transmission characters into a single serial bit stream. The data source presents a 20-bit bus. In narrow mode one 10-bit character is taken from the low half of that bus for each word. In wide mode the whole 20-bit word is captured, and a two-way character selector sends the upper character first and then the lower one. The block also drives the word clock that the data source follows. A new word is captured at the same clock edge where that word clock rises. The source then has the rest of the word time to present the next word.

All logic runs on one reference clock. Serial bit timing is modelled as a bit enable derived from that clock. A rate select sets the bit period to one, two or four reference cycles. A reference select doubles that period, for the case where the reference runs twice as fast as the plain divider expects. A loopback control moves the stream from the main serial output to a test output, so the serial path can be exercised offline. The mode inputs are treated as static: change them only while reset is held.

Top module: `ser_dual_width_tx`

## Requirements
- R1: While `rst` is high at a clock edge, `wclk_o`, `sdo_o` and `tst_o` are driven low.
- R2: In narrow mode (`wide_mode`=0), each word contributes `din[9:0]` only, sent least significant bit first. `din[19:10]` has no effect. The value taken is the one on `din` at the clock edge where `wclk_o` rises.
- R3: In wide mode (`wide_mode`=1), each captured word is sent as `din[19:10]` first and then `din[9:0]`, each character least significant bit first. The low character comes from the same capture edge as the high one.
- R4: One serial bit lasts B×M reference cycles. B is the base: 1 for `rate_sel`=00, 2 for 01, and 4 for 10 or 11. M is 2 when `ref_fast`=1 and 1 otherwise.
- R5: Characters follow one another with no idle bit or repeated bit. The first bit of the next character directly follows the last bit of the current one.
- R6: `wclk_o` is high for the first half of each word time and low for the second half. That is 5 high and 5 low bit times in narrow mode, and 10 high and 10 low in wide mode. Its edges occur only at bit boundaries.
- R7: After reset is released, both serial outputs stay low and `wclk_o` stays low for exactly 10 bit times. `wclk_o` then rises, in the same reference cycle that the first character starts.
- R8: With `loop_en`=1 the stream appears on `tst_o` and `sdo_o` is held low. With `loop_en`=0 the stream appears on `sdo_o` and `tst_o` is held low. A change of `loop_en` takes effect at the next clock edge.
- R9: `sdo_o` and `tst_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 0: one 10-bit character per word; 1: two characters per 20-bit word |
| rate_sel | input | 2 | Base bit period: 00 one, 01 two, 10/11 four reference cycles |
| ref_fast | input | 1 | 1 doubles the bit period (reference at twice the needed rate) |
| loop_en | input | 1 | 1 steers the serial stream to the test output |
| din | input | 20 | Parallel word; low character in [9:0], high character in [19:10] |
| wclk_o | output | 1 | Word clock to the data source; rises when a word is captured |
| sdo_o | output | 1 | Main serial data output |
| tst_o | output | 1 | Loopback test serial output |

## Verification
Several things can land in one reference cycle: the last shift of a character, the reload of the shift register, the capture of a new parallel word, and the rise of the word clock. In wide mode the switch to the held low character lands on the same edge as the fall of the word clock. The tightest case is a bit period of one cycle, where a bit enable is present every cycle. Runs in that setting use a fresh word value each time. The scoreboard then expects every bit in unbroken order and checks the word clock level at each bit. A gap, a repeated bit or a stale word shows up as a mismatch against the queued bits.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [1:0] {
    RATE_FULL    = 2'd0,
    RATE_HALF    = 2'd1,
    RATE_QUARTER = 2'd2,
    RATE_SPARE   = 2'd3
  } rate_e;
endpackage

// File: rtl/ser_pace.sv
// Bit-enable generator: one pulse per serial bit time.
module ser_pace #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  input  logic       ref_fast,
  output logic       bit_en
);
  import ser_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] lim;

  always_comb begin
    case (rate_e'(rate_sel))
      RATE_FULL: base = CNT_W'(1);
      RATE_HALF: base = CNT_W'(2);
      default:   base = CNT_W'(4);
    endcase
    period = ref_fast ? (base << 1) : base;
    lim    = period - CNT_W'(1);
    bit_en = (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (bit_en) cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/ser_char_sel.sv
// Character selector: picks the next character for the shifter.
module ser_char_sel #(
  parameter int CHAR_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wide_mode,
  input  logic                  load,
  input  logic [2*CHAR_W-1:0]   din,
  output logic [CHAR_W-1:0]     nxt_chr,
  output logic                  word_start
);
  logic              second;
  logic [CHAR_W-1:0] low_q;

  always_comb begin
    word_start = !(wide_mode && second);
    if (!wide_mode)  nxt_chr = din[CHAR_W-1:0];
    else if (second) nxt_chr = low_q;
    else             nxt_chr = din[2*CHAR_W-1:CHAR_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      second <= 1'b0;
      low_q  <= '0;
    end else if (load) begin
      if (wide_mode && !second) begin
        low_q  <= din[CHAR_W-1:0];
        second <= 1'b1;
      end else begin
        second <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ser_shift.sv
// Character shifter: LSB-first shift with gapless reload and output steering.
module ser_shift #(
  parameter int CHAR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              loop_en,
  input  logic [CHAR_W-1:0] nxt_chr,
  output logic              load,
  output logic              mid,
  output logic              sdo_o,
  output logic              tst_o
);
  localparam int BC_W = $clog2(CHAR_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(CHAR_W - 1);
  localparam logic [BC_W-1:0] MID_BIT  = BC_W'(CHAR_W / 2 - 1);

  logic [BC_W-1:0]   bc;
  logic [CHAR_W-1:0] sr;
  logic [CHAR_W-1:0] sr_d;

  always_comb begin
    load = bit_en && (bc == LAST_BIT);
    mid  = bit_en && (bc == MID_BIT);
    if (load)        sr_d = nxt_chr;
    else if (bit_en) sr_d = {1'b0, sr[CHAR_W-1:1]};
    else             sr_d = sr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bc    <= '0;
      sr    <= '0;
      sdo_o <= 1'b0;
      tst_o <= 1'b0;
    end else begin
      if (load)        bc <= '0;
      else if (bit_en) bc <= bc + BC_W'(1);
      sr    <= sr_d;
      sdo_o <= !loop_en && sr_d[0];
      tst_o <= loop_en && sr_d[0];
    end
  end
endmodule

// File: rtl/ser_dual_width_tx.sv
module ser_dual_width_tx #(
  parameter int CHAR_W = 10,
  parameter int CNT_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wide_mode,
  input  logic [1:0]          rate_sel,
  input  logic                ref_fast,
  input  logic                loop_en,
  input  logic [2*CHAR_W-1:0] din,
  output logic                wclk_o,
  output logic                sdo_o,
  output logic                tst_o
);
  logic              bit_en;
  logic              load;
  logic              mid;
  logic              word_start;
  logic [CHAR_W-1:0] nxt_chr;

  ser_pace #(.CNT_W(CNT_W)) i_pace (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .ref_fast(ref_fast),
    .bit_en(bit_en)
  );

  ser_char_sel #(.CHAR_W(CHAR_W)) i_sel (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .load(load), .din(din),
    .nxt_chr(nxt_chr), .word_start(word_start)
  );

  ser_shift #(.CHAR_W(CHAR_W)) i_shift (
    .clk(clk), .rst(rst), .bit_en(bit_en), .loop_en(loop_en),
    .nxt_chr(nxt_chr), .load(load), .mid(mid),
    .sdo_o(sdo_o), .tst_o(tst_o)
  );

  // Word clock: rises with each word capture, falls at the half-word point.
  always_ff @(posedge clk) begin
    if (rst)                                     wclk_o <= 1'b0;
    else if (load && word_start)                 wclk_o <= 1'b1;
    else if ((load && !word_start) ||
             (mid && !wide_mode))                wclk_o <= 1'b0;
  end
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic loop_en,
  input logic wclk_o,
  input logic sdo_o,
  input logic tst_o
);
  logic started;

  always_ff @(posedge clk) begin
    if (rst)         started <= 1'b0;
    else if (wclk_o) started <= 1'b1;
  end

  a_r9_outputs_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(sdo_o && tst_o));

  a_r8_main_quiet_in_loop: assert property (@(posedge clk) disable iff (rst)
    $past(loop_en) |-> !sdo_o);

  a_r8_test_quiet_normal: assert property (@(posedge clk) disable iff (rst)
    !$past(loop_en) |-> !tst_o);

  a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
    (!started && !wclk_o) |-> (!sdo_o && !tst_o));

  a_r6_wclk_on_bit: assert property (@(posedge clk) disable iff (rst)
    ($rose(wclk_o) || $fell(wclk_o)) |-> $past(bit_en));

  a_r4_hold_between_bits: assert property (@(posedge clk) disable iff (rst)
    (!$past(bit_en) && ($past(loop_en) == $past(loop_en, 2)))
      |-> ($stable(sdo_o) && $stable(tst_o)));
endmodule

bind ser_dual_width_tx ser_tx_chk i_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .loop_en(loop_en),
  .wclk_o(wclk_o), .sdo_o(sdo_o), .tst_o(tst_o)
);

// File: tb/test_ser_dual_width_tx.sv
module test_ser_dual_width_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_mode = 1'b0;
  logic [1:0]  rate_sel = 2'd0;
  logic        ref_fast = 1'b0;
  logic        loop_en = 1'b0;
  logic [19:0] din = '0;
  logic        wclk_o, sdo_o, tst_o;

  int   n_cmp = 0;
  int   n_bad = 0;
  int   cycles = 0;
  logic exp_q[$];

  always #10 clk = ~clk;

  ser_dual_width_tx i_ser_dual_width_tx (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .rate_sel(rate_sel),
    .ref_fast(ref_fast), .loop_en(loop_en), .din(din),
    .wclk_o(wclk_o), .sdo_o(sdo_o), .tst_o(tst_o)
  );

  task automatic compare(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compare_int(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [19:0] word_of(input int k, input int seed);
    return 20'((k * 32'h9E37) ^ (seed * 32'h5A5) ^ 32'hC3A5A ^ (k << 7));
  endfunction

  // Driver side of the scoreboard: queue the bits a word must produce.
  task automatic push_word(input logic [19:0] w, input bit wide);
    if (wide) begin
      for (int i = 10; i < 20; i++) exp_q.push_back(w[i]);   // R3 high first
      for (int i = 0; i < 10; i++) exp_q.push_back(w[i]);
    end else begin
      for (int i = 0; i < 10; i++) exp_q.push_back(w[i]);    // R2 LSB first
    end
  endtask

  task automatic wait_rise();
    while (wclk_o !== 1'b0) @(negedge clk);
    while (wclk_o !== 1'b1) @(negedge clk);
  endtask

  task automatic run_mode(input bit wide, input logic [1:0] rate, input bit rf,
                          input bit lb, input int nwords, input int seed,
                          input string req);
    int per;
    int wbits;
    per   = ((rate == 2'd0) ? 1 : (rate == 2'd1) ? 2 : 4) * (rf ? 2 : 1);
    wbits = wide ? 20 : 10;
    @(negedge clk);
    rst = 1'b1;
    wide_mode = wide; rate_sel = rate; ref_fast = rf; loop_en = lb;
    exp_q.delete();
    din = word_of(0, seed);
    push_word(word_of(0, seed), wide);
    repeat (3) @(negedge clk);
    compare("R1 wclk in reset", wclk_o, 1'b0);
    compare("R1 sdo in reset", sdo_o, 1'b0);
    compare("R1 tst in reset", tst_o, 1'b0);
    rst = 1'b0;
    fork
      begin : drv
        for (int k = 1; k < nwords; k++) begin
          wait_rise();
          din = word_of(k, seed);
          push_word(word_of(k, seed), wide);
        end
      end
      begin : mon
        int  cnt;
        bit  idle_ok;
        cnt = 0;
        idle_ok = 1'b1;
        do begin
          @(negedge clk);
          cnt++;
          if (wclk_o !== 1'b1 && (sdo_o !== 1'b0 || tst_o !== 1'b0)) idle_ok = 1'b0;
        end while (wclk_o !== 1'b1 && cnt < 1000);
        compare_int("R7 cycles before first word clock", cnt, 10 * per);
        compare("R7 outputs low while idle", idle_ok, 1'b1);
        for (int j = 0; j < nwords * wbits; j++) begin
          logic e;
          if (j > 0) repeat (per) @(negedge clk);
          if (exp_q.size() == 0) begin
            compare({req, " R5 queue underrun"}, 1'b1, 1'b0);
            e = 1'b0;
          end else begin
            e = exp_q.pop_front();
          end
          compare({req, " R5 serial bit"}, lb ? tst_o : sdo_o, e);
          compare("R8 unused output low", lb ? sdo_o : tst_o, 1'b0);
          compare("R6 word clock level", wclk_o, ((j % wbits) < (wbits / 2)) ? 1'b1 : 1'b0);
        end
      end
    join
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    run_mode(1'b0, 2'd0, 1'b0, 1'b0, 8, 1, "R2 R4 narrow full");
    run_mode(1'b1, 2'd0, 1'b0, 1'b0, 6, 2, "R3 R4 wide full");
    run_mode(1'b0, 2'd1, 1'b0, 1'b0, 5, 3, "R4 narrow half");
    run_mode(1'b0, 2'd2, 1'b0, 1'b0, 4, 4, "R4 narrow quarter");
    run_mode(1'b0, 2'd3, 1'b1, 1'b0, 3, 5, "R4 narrow quarter ref doubled");
    run_mode(1'b1, 2'd1, 1'b1, 1'b0, 4, 6, "R3 R4 wide half ref doubled");
    run_mode(1'b0, 2'd0, 1'b0, 1'b1, 5, 7, "R8 R9 narrow loopback");
    run_mode(1'b1, 2'd0, 1'b1, 1'b1, 4, 8, "R8 R9 wide loopback");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule